// File: doc/BRIEF.md
# Circulant Message Alignment Unit

This unit serves one 256 x 256 circulant permutation block of a quasi-cyclic LDPC decoder whose edge messages are packed four to a 32-bit memory word. Lane j of a word sits in bits [8j+7:8j], and word w holds the messages of columns 4w to 4w+3, stored in variable-node order. A circulant with shift `offset` links its row r to column (r + offset) mod 256.

A start pulse selects a traversal order and captures the shift. The unit then issues 64 vector reads, one per cycle. In variable order, step k simply fetches word k. In check order, step k needs the messages of columns 4k+offset to 4k+offset+3. Unless the shift is a multiple of four, these columns straddle two words. Both words are read at once through two read ports, and the lanes are rotated down by offset mod 4, so that lane j of the output always feeds processing lane j.

Results come back through a write-back port. The same mapping is inverted there: each lane is scattered to its column through byte-lane write enables on one or two words.

Top module: `circ_align_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `vec_valid` is 0, `mem_ren` is 0 and both byte-enable outputs are 0.
- R2: A `start` accepted while idle captures `order_sel` (0 = variable order, 1 = check order) and `offset`. It then holds `mem_ren` high for exactly 64 consecutive cycles, with step index k running 0,1,...,63.
- R3: `vec_valid` is high exactly one cycle after each cycle in which `mem_ren` is high, and `vec_step` equals the k of that read.
- R4: In variable order, read port A addresses word k, the vector is word k unchanged, and the offset has no effect.
- R5: In check order, lane j (bits [8j+7:8j]) of vector k carries the message of column (4k + j + offset) mod 256. Column c lives in word c/4, lane c mod 4.
- R6: Read port A addresses word (k + offset/4) mod 64 in check order, and port B always addresses (port A + 1) mod 64, wrapping 63 to 0.
- R7: A `start` that arrives while a traversal is active is ignored. The running traversal keeps its order and shift and still issues exactly 64 reads.
- R8: In variable order, write-back step k writes all four lanes of word k on port A one cycle after `wb_valid`, and port B enables no byte.
- R9: In check order, lane j of write-back step k lands at column (4k + j + offset) mod 256. Port A enables bytes q..3 and port B enables bytes 0..q-1 (q = offset mod 4). Port B targets the word after port A's.
- R10: A cycle with `wb_valid` low produces no byte enable in the next cycle, whatever `wb_data` and `wb_step` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a 64-step traversal when idle |
| order_sel | input | 1 | 0 variable order, 1 check order |
| offset | input | 8 | Circulant shift |
| mem_ren | output | 1 | Read enable for both read ports |
| mem_raddr_a | output | 6 | Read port A word address |
| mem_raddr_b | output | 6 | Read port B word address |
| mem_rdata_a | input | 32 | Port A data, one cycle after address |
| mem_rdata_b | input | 32 | Port B data, one cycle after address |
| vec_valid | output | 1 | Aligned vector present |
| vec_step | output | 6 | Step index of the vector |
| vec_data | output | 32 | Aligned four-lane vector |
| wb_valid | input | 1 | Write-back vector present |
| wb_step | input | 6 | Step index of the write-back vector |
| wb_data | input | 32 | Write-back vector in processing-lane order |
| mem_waddr_a | output | 6 | Write port A word address |
| mem_wdata_a | output | 32 | Write port A data |
| mem_wbe_a | output | 4 | Write port A byte enables |
| mem_waddr_b | output | 6 | Write port B word address |
| mem_wdata_b | output | 32 | Write port B data |
| mem_wbe_b | output | 4 | Write port B byte enables |

## Verification
Several properties are checked on every cycle. The read valid trails the read enable by one cycle, and the step count advances by one while reads continue. Port B reads the word after port A. A start during a run leaves the captured shift untouched. Whenever port B is enabled, the two byte-enable masks are disjoint and together cover all four lanes. Other behaviour can only be shown by the bench's scenarios, which compare against a shadow array of messages indexed by column: the lane contents after rotation, the exact start address for each shift, the wrap near shifts 254 and 255, and the fact that a full check-order write-back followed by a plain read-out puts every message in the right column.

// File: rtl/circ_align_pkg.sv
package circ_align_pkg;

    parameter int unsigned CIRC_SIZE = 256;
    parameter int unsigned LANES     = 4;
    parameter int unsigned MSG_W     = 8;

    localparam int unsigned WORDS = CIRC_SIZE / LANES;
    localparam int unsigned AW    = $clog2(WORDS);
    localparam int unsigned LW    = $clog2(LANES);
    localparam int unsigned VW    = LANES * MSG_W;
    localparam int unsigned OFF_W = $clog2(CIRC_SIZE);

    typedef enum logic {
        ORD_VAR = 1'b0,
        ORD_CHK = 1'b1
    } order_e;

    typedef struct packed {
        order_e          ord;
        logic [AW-1:0]   wshift;
        logic [LW-1:0]   lshift;
    } trav_cfg_t;

    function automatic trav_cfg_t make_cfg(input order_e o, input logic [OFF_W-1:0] off);
        trav_cfg_t c;
        c.ord = o;
        if (o == ORD_CHK) begin
            c.wshift = off[OFF_W-1:LW];
            c.lshift = off[LW-1:0];
        end else begin
            c.wshift = '0;
            c.lshift = '0;
        end
        return c;
    endfunction

endpackage

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import circ_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  order_e            order_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic              ren,
    output logic [AW-1:0]     raddr_a,
    output logic [AW-1:0]     raddr_b,
    output logic [AW-1:0]     issue_step,
    output trav_cfg_t         cfg_q,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_step,
    output logic [LW-1:0]     rd_lshift
);

    localparam logic [AW-1:0] LAST_STEP = AW'(WORDS - 1);

    logic          running;
    logic [AW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            step_q    <= '0;
            cfg_q     <= '0;
            rd_valid  <= 1'b0;
            rd_step   <= '0;
            rd_lshift <= '0;
        end else begin
            rd_valid  <= running;
            rd_step   <= step_q;
            rd_lshift <= cfg_q.lshift;
            if (!running) begin
                if (start) begin
                    running <= 1'b1;
                    step_q  <= '0;
                    cfg_q   <= make_cfg(order_sel, offset);
                end
            end else begin
                step_q <= step_q + 1'b1;
                if (step_q == LAST_STEP) begin
                    running <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        ren        = running;
        issue_step = step_q;
        raddr_a    = step_q + cfg_q.wshift;
        raddr_b    = raddr_a + 1'b1;
    end

endmodule

// File: rtl/circ_lane_rotator.sv
module circ_lane_rotator
    import circ_align_pkg::*;
(
    input  logic [VW-1:0]  word_a,
    input  logic [VW-1:0]  word_b,
    input  logic [LW-1:0]  lshift,
    output logic [VW-1:0]  vec
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LW:0] src;
        assign src = (LW+1)'(j) + {1'b0, lshift};
        assign vec[j*MSG_W +: MSG_W] = src[LW] ? word_b[src[LW-1:0]*MSG_W +: MSG_W]
                                               : word_a[src[LW-1:0]*MSG_W +: MSG_W];
    end

endmodule

// File: rtl/circ_wb_align.sv
module circ_wb_align
    import circ_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_valid,
    input  logic [AW-1:0]     wb_step,
    input  logic [VW-1:0]     wb_data,
    input  trav_cfg_t         cfg,
    output logic [AW-1:0]     waddr_a,
    output logic [VW-1:0]     wdata_a,
    output logic [LANES-1:0]  wbe_a,
    output logic [AW-1:0]     waddr_b,
    output logic [VW-1:0]     wdata_b,
    output logic [LANES-1:0]  wbe_b
);

    logic [VW-1:0]    nxt_data_a, nxt_data_b;
    logic [LANES-1:0] nxt_be_a, nxt_be_b;
    logic [AW-1:0]    nxt_addr_a;

    // For each byte position of the target words, find which processing lane feeds it.
    for (genvar p = 0; p < LANES; p++) begin : g_byte
        logic [LW:0]    diff;
        logic [MSG_W-1:0] src_msg;
        assign diff    = (LW+1)'(p) + (LW+1)'(LANES) - {1'b0, cfg.lshift};
        assign src_msg = wb_data[diff[LW-1:0]*MSG_W +: MSG_W];
        assign nxt_be_a[p] = diff[LW];
        assign nxt_be_b[p] = ~diff[LW];
        assign nxt_data_a[p*MSG_W +: MSG_W] = diff[LW] ? src_msg : '0;
        assign nxt_data_b[p*MSG_W +: MSG_W] = diff[LW] ? '0 : src_msg;
    end

    assign nxt_addr_a = wb_step + cfg.wshift;

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr_a <= '0;
            waddr_b <= '0;
            wdata_a <= '0;
            wdata_b <= '0;
            wbe_a   <= '0;
            wbe_b   <= '0;
        end else if (wb_valid) begin
            waddr_a <= nxt_addr_a;
            waddr_b <= nxt_addr_a + 1'b1;
            wdata_a <= nxt_data_a;
            wdata_b <= nxt_data_b;
            wbe_a   <= nxt_be_a;
            wbe_b   <= nxt_be_b;
        end else begin
            wbe_a   <= '0;
            wbe_b   <= '0;
        end
    end

endmodule

// File: rtl/circ_align_unit.sv
module circ_align_unit
    import circ_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              order_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic              mem_ren,
    output logic [AW-1:0]     mem_raddr_a,
    output logic [AW-1:0]     mem_raddr_b,
    input  logic [VW-1:0]     mem_rdata_a,
    input  logic [VW-1:0]     mem_rdata_b,
    output logic              vec_valid,
    output logic [AW-1:0]     vec_step,
    output logic [VW-1:0]     vec_data,
    input  logic              wb_valid,
    input  logic [AW-1:0]     wb_step,
    input  logic [VW-1:0]     wb_data,
    output logic [AW-1:0]     mem_waddr_a,
    output logic [VW-1:0]     mem_wdata_a,
    output logic [LANES-1:0]  mem_wbe_a,
    output logic [AW-1:0]     mem_waddr_b,
    output logic [VW-1:0]     mem_wdata_b,
    output logic [LANES-1:0]  mem_wbe_b
);

    trav_cfg_t     cfg_q;
    logic [AW-1:0] issue_step;
    logic [LW-1:0] rd_lshift;

    circ_addr_gen u_addr (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .order_sel  (order_e'(order_sel)),
        .offset     (offset),
        .ren        (mem_ren),
        .raddr_a    (mem_raddr_a),
        .raddr_b    (mem_raddr_b),
        .issue_step (issue_step),
        .cfg_q      (cfg_q),
        .rd_valid   (vec_valid),
        .rd_step    (vec_step),
        .rd_lshift  (rd_lshift)
    );

    circ_lane_rotator u_rot (
        .word_a (mem_rdata_a),
        .word_b (mem_rdata_b),
        .lshift (rd_lshift),
        .vec    (vec_data)
    );

    circ_wb_align u_wb (
        .clk      (clk),
        .rst      (rst),
        .wb_valid (wb_valid),
        .wb_step  (wb_step),
        .wb_data  (wb_data),
        .cfg      (cfg_q),
        .waddr_a  (mem_waddr_a),
        .wdata_a  (mem_wdata_a),
        .wbe_a    (mem_wbe_a),
        .waddr_b  (mem_waddr_b),
        .wdata_b  (mem_wdata_b),
        .wbe_b    (mem_wbe_b)
    );

endmodule

// File: rtl/circ_align_chk.sv
module circ_align_chk
    import circ_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mem_ren,
    input  logic [AW-1:0]     mem_raddr_a,
    input  logic [AW-1:0]     mem_raddr_b,
    input  logic [AW-1:0]     issue_step,
    input  trav_cfg_t         cfg_q,
    input  logic              vec_valid,
    input  logic              wb_valid,
    input  logic [AW-1:0]     mem_waddr_a,
    input  logic [AW-1:0]     mem_waddr_b,
    input  logic [LANES-1:0]  mem_wbe_a,
    input  logic [LANES-1:0]  mem_wbe_b
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!vec_valid && !mem_ren && mem_wbe_a == '0 && mem_wbe_b == '0));

    // R3
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid == $past(mem_ren));

    // R2
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_ren && $past(mem_ren)) |-> issue_step == $past(issue_step) + 1'b1);

    // R6
    port_b_next_word_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ren |-> mem_raddr_b == mem_raddr_a + 1'b1);

    // R7
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_ren && start) |=> cfg_q == $past(cfg_q));

    // R9
    split_write_masks_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wbe_b != '0) |-> ((mem_wbe_a | mem_wbe_b) == '1 && (mem_wbe_a & mem_wbe_b) == '0
                               && mem_waddr_b == mem_waddr_a + 1'b1));

    // R10
    no_write_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wb_valid) |-> (mem_wbe_a == '0 && mem_wbe_b == '0));

endmodule

bind circ_align_unit circ_align_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mem_ren     (mem_ren),
    .mem_raddr_a (mem_raddr_a),
    .mem_raddr_b (mem_raddr_b),
    .issue_step  (issue_step),
    .cfg_q       (cfg_q),
    .vec_valid   (vec_valid),
    .wb_valid    (wb_valid),
    .mem_waddr_a (mem_waddr_a),
    .mem_waddr_b (mem_waddr_b),
    .mem_wbe_a   (mem_wbe_a),
    .mem_wbe_b   (mem_wbe_b)
);

// File: tb/test_circ_align_unit.sv
module test_circ_align_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NCASE = 8;
    // {order, offset, expected first port-A address}
    localparam logic [14:0] CASES [0:NCASE-1] = '{
        {1'b0, 8'd0,   6'd0},
        {1'b1, 8'd0,   6'd0},
        {1'b1, 8'd3,   6'd0},
        {1'b1, 8'd5,   6'd1},
        {1'b1, 8'd254, 6'd63},
        {1'b1, 8'd255, 6'd63},
        {1'b1, 8'd130, 6'd32},
        {1'b0, 8'd77,  6'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        order_sel = 1'b0;
    logic [7:0]  offset = '0;
    logic        mem_ren;
    logic [5:0]  mem_raddr_a, mem_raddr_b;
    logic [31:0] mem_rdata_a, mem_rdata_b;
    logic        vec_valid;
    logic [5:0]  vec_step;
    logic [31:0] vec_data;
    logic        wb_valid = 1'b0;
    logic [5:0]  wb_step = '0;
    logic [31:0] wb_data = '0;
    logic [5:0]  mem_waddr_a, mem_waddr_b;
    logic [31:0] mem_wdata_a, mem_wdata_b;
    logic [3:0]  mem_wbe_a, mem_wbe_b;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem [0:63];
    logic [7:0]  shadow [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    circ_align_unit i_circ_align_unit (
        .clk(clk), .rst(rst), .start(start), .order_sel(order_sel), .offset(offset),
        .mem_ren(mem_ren), .mem_raddr_a(mem_raddr_a), .mem_raddr_b(mem_raddr_b),
        .mem_rdata_a(mem_rdata_a), .mem_rdata_b(mem_rdata_b),
        .vec_valid(vec_valid), .vec_step(vec_step), .vec_data(vec_data),
        .wb_valid(wb_valid), .wb_step(wb_step), .wb_data(wb_data),
        .mem_waddr_a(mem_waddr_a), .mem_wdata_a(mem_wdata_a), .mem_wbe_a(mem_wbe_a),
        .mem_waddr_b(mem_waddr_b), .mem_wdata_b(mem_wdata_b), .mem_wbe_b(mem_wbe_b)
    );

    // Memory model: two read ports with one-cycle latency, two byte-enabled write ports.
    always @(posedge clk) begin
        if (mem_ren) begin
            mem_rdata_a <= mem[mem_raddr_a];
            mem_rdata_b <= mem[mem_raddr_b];
        end
        for (int p = 0; p < 4; p++) begin
            if (mem_wbe_a[p]) mem[mem_waddr_a][p*8 +: 8] <= mem_wdata_a[p*8 +: 8];
            if (mem_wbe_b[p]) mem[mem_waddr_b][p*8 +: 8] <= mem_wdata_b[p*8 +: 8];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic int col_of(input logic ord, input logic [7:0] off, input int k, input int j);
        return ord ? ((4*k + j + int'(off)) % 256) : (4*k + j);
    endfunction

    task automatic run_phase(input logic ord, input logic [7:0] off, input int glitch_at,
                             input logic [5:0] exp_a0);
        int seen = 0;
        int issued = 0;
        @(negedge clk);
        start = 1'b1; order_sel = ord; offset = off;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 80; cyc++) begin
            if (mem_ren) begin
                logic [5:0] ea;
                ea = ord ? 6'((issued + int'(off)/4) % 64) : 6'(issued);
                if (issued == 0)
                    check(mem_raddr_a == exp_a0, "R6", "first port A address", 32'(mem_raddr_a), 32'(exp_a0));
                check(mem_raddr_a == ea, ord ? "R6" : "R4", "port A address", 32'(mem_raddr_a), 32'(ea));
                check(mem_raddr_b == ea + 6'd1, "R6", "port B address", 32'(mem_raddr_b), 32'(ea + 6'd1));
                issued++;
            end
            if (vec_valid) begin
                logic [31:0] ev;
                for (int j = 0; j < 4; j++) ev[j*8 +: 8] = shadow[col_of(ord, off, seen, j)];
                check(vec_step == 6'(seen), "R3", "vector step", 32'(vec_step), 32'(seen));
                check(vec_data == ev, ord ? "R5" : "R4", "vector data", vec_data, ev);
                seen++;
            end
            if (cyc == glitch_at) begin
                start = 1'b1; order_sel = ~ord; offset = off + 8'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(issued == 64, glitch_at >= 0 ? "R7" : "R2", "read count", 32'(issued), 32'd64);
        check(seen == 64, "R3", "vector count", 32'(seen), 32'd64);
    endtask

    task automatic wb_phase(input logic ord, input logic [7:0] off);
        int q = int'(off) % 4;
        int s = int'(off) / 4;
        logic [3:0] ea_be, eb_be;
        ea_be = ord ? 4'((4'hF << q) & 4'hF) : 4'hF;
        eb_be = ord ? 4'((1 << q) - 1) : 4'h0;
        run_phase(ord, off, -1, ord ? 6'(s) : 6'd0);
        for (int k = 0; k <= 64; k++) begin
            @(negedge clk);
            if (k > 0) begin
                logic [5:0] ea;
                ea = ord ? 6'((k - 1 + s) % 64) : 6'(k - 1);
                check(mem_wbe_a == ea_be, ord ? "R9" : "R8", "port A byte enables", 32'(mem_wbe_a), 32'(ea_be));
                check(mem_wbe_b == eb_be, ord ? "R9" : "R8", "port B byte enables", 32'(mem_wbe_b), 32'(eb_be));
                check(mem_waddr_a == ea, ord ? "R9" : "R8", "write address A", 32'(mem_waddr_a), 32'(ea));
                if (eb_be != 0)
                    check(mem_waddr_b == ea + 6'd1, "R9", "write address B", 32'(mem_waddr_b), 32'(ea + 6'd1));
            end
            if (k < 64) begin
                logic [31:0] d;
                for (int j = 0; j < 4; j++) begin
                    d[j*8 +: 8] = 8'(200 - (4*k + j) * 3 + int'(off));
                    shadow[col_of(ord, off, k, j)] = d[j*8 +: 8];
                end
                wb_valid = 1'b1; wb_step = 6'(k); wb_data = d;
            end else begin
                wb_valid = 1'b0; wb_step = 6'd17; wb_data = 32'hDEADBEEF;
            end
        end
        @(negedge clk);
        check(mem_wbe_a == 0 && mem_wbe_b == 0, "R10", "enables with wb_valid low",
              {24'd0, mem_wbe_a, mem_wbe_b}, 32'd0);
        @(negedge clk);
        // Read back in plain order: every column must hold what the shadow says.
        run_phase(1'b0, 8'd0, -1, 6'd0);
    endtask

    initial begin
        for (int c = 0; c < 256; c++) shadow[c] = 8'((c * 37 + 11) & 255);
        for (int w = 0; w < 64; w++)
            for (int j = 0; j < 4; j++) mem[w][j*8 +: 8] = shadow[4*w + j];

        repeat (3) @(negedge clk);
        check(!vec_valid && !mem_ren, "R1", "valid/ren in reset", {30'd0, vec_valid, mem_ren}, 32'd0);
        check(mem_wbe_a == 0 && mem_wbe_b == 0, "R1", "enables in reset", {24'd0, mem_wbe_a, mem_wbe_b}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!vec_valid && !mem_ren, "R1", "idle after reset", {30'd0, vec_valid, mem_ren}, 32'd0);

        for (int i = 0; i < NCASE; i++)
            run_phase(CASES[i][14], CASES[i][13:6], -1, CASES[i][5:0]);

        // R7: start during an active check-order run with offset 6
        run_phase(1'b1, 8'd6, 10, 6'd1);

        // R8 / R9 / R10 write-back, then read-back
        wb_phase(1'b0, 8'd0);
        wb_phase(1'b1, 8'd7);
        wb_phase(1'b1, 8'd255);
        run_phase(1'b1, 8'd130, -1, 6'd32);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1; order_sel = 1'b1; offset = 8'd9;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!vec_valid && !mem_ren, "R1", "mid-run reset", {30'd0, vec_valid, mem_ren}, 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!vec_valid && !mem_ren, "R1", "stays idle after reset", {30'd0, vec_valid, mem_ren}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule